// File: doc/BRIEF.md
# Cube Absorption Array

This block reduces a sum of cube products by Boolean absorption. Cubes arrive one per accepted input beat and travel through a row of moving slots. Beside that row sits a row of resident slots with the same indices. At every index a detector compares the moving cube with the resident cube. Whichever cube is more general (has fewer literals) stays, and the more specific one is erased. A new cube that reaches an empty resident slot takes that slot.

The upstream producer marks the final cube of a sum. The block then pushes empty cubes through the moving row so that every cube still travelling is resolved. It then copies the resident row into an output buffer in one cycle and clears the array. The buffer streams the surviving cubes in slot order, one per cycle, while the array already accepts the next sum. A sum that leaves no survivor is reported as a single all-zero cube, which means the product has no solution.

Top module: `cube_absorb_array`

## Requirements
- R1: A cube holds two bits per variable, with variable i at bits [2i+1:2i]: 2'b10 is the true literal, 2'b01 the complemented literal, 2'b11 means the variable is absent, and 2'b00 is a contradiction. An input cube with any 2'b00 field is treated as the empty cube (all zeros): it is dropped, and no output cube other than the all-zero marker of R10 carries a 2'b00 field.
- R2: While reset is asserted and after it is released, every slot is empty, out_valid is low and in_ready is high.
- R3: A cube is accepted on a clock edge where in_valid and in_ready are both high. Accepted cubes visit slots 0 to DEPTH-1 in arrival order. At each slot the rules R4 to R7 apply to the cube as it stands after the earlier slots. The outcome equals processing the cubes one after another against the resident row.
- R4: A non-empty moving cube that meets an empty resident slot is copied into that slot and stops travelling.
- R5: When the resident cube is contained in the moving cube (resident & ~moving == 0, which includes identical cubes), the moving cube replaces the resident and stops travelling.
- R6: Otherwise, when the moving cube is contained in the resident cube, the moving cube is erased.
- R7: A cube that neither contains nor is contained in the resident cube keeps travelling. A cube still travelling after slot DEPTH-1 is lost, so a sum keeps at most DEPTH cubes.
- R8: After the edge that accepts a cube with in_last high, in_ready stays low for at least DEPTH+1 cycles (exactly DEPTH+1 when no earlier stream is pending). in_valid, in_cube and in_last are ignored during that time.
- R9: The first output beat of a sum appears DEPTH+1 edges after the accepting edge of its last cube. The survivors follow in ascending slot index, one per cycle with out_valid high, and out_last marks the final beat.
- R10: A sum with no surviving cube produces exactly one beat with out_valid and out_last high and out_cube all zeros.
- R11: A new sum may be accepted while the previous one streams out. Each beat with out_last is followed by a cycle with out_valid low.
- R12: The array is empty at the start of every sum, so results do not depend on earlier sums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input cube present |
| in_cube | input | 2*NVARS | Input cube |
| in_last | input | 1 | Input cube closes the current sum |
| in_ready | output | 1 | Block accepts input this cycle |
| out_valid | output | 1 | Output beat present |
| out_cube | output | 2*NVARS | Surviving cube, or all zeros for an empty result |
| out_last | output | 1 | Final beat of the current sum |

## Verification
The checker watches the port protocol on every cycle:
- in_ready drops after a closing cube and stays low for the drain and transfer window.
- Output beats are contiguous up to out_last, and an idle cycle separates two sums.
- No contradictory cube leaves the block, and the all-zero marker only appears as a lone final beat.

Which cubes survive, their slot order, loss on overflow, and freedom from state left over by earlier sums depend on the sequence of inputs. Only the bench scenarios can show these: an exhaustive sweep over every ordered pair of cubes, a pseudo-random sweep of longer sums with contradictory inputs mixed in, an overflow case and back-to-back sums. Each is compared against a sequential model of the slot rules.

// File: rtl/cab_pkg.sv
package cab_pkg;

   typedef enum logic [1:0] {
      CAB_COLLECT = 2'd0,
      CAB_DRAIN   = 2'd1,
      CAB_XFER    = 2'd2
   } cab_state_e;

endpackage

// File: rtl/cab_cell.sv
// One index of the array: a moving register, a resident register and the
// domination detector that resolves the pair on every step.
module cab_cell #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         wipe,
   input  logic [W-1:0] mv_in,
   output logic [W-1:0] mv_q,
   output logic [W-1:0] res_q
);

   logic [W-1:0] mv_nx;
   logic [W-1:0] res_nx;
   logic         mv_live;
   logic         res_live;
   logic         res_in_mv;
   logic         mv_in_res;

   assign mv_live   = |mv_in;
   assign res_live  = |res_q;
   assign res_in_mv = ~|(res_q & ~mv_in);
   assign mv_in_res = ~|(mv_in & ~res_q);

   always_comb begin
      mv_nx  = mv_in;
      res_nx = res_q;
      if (mv_live) begin
         if (!res_live || res_in_mv) begin
            // free slot, or the resident is the more specific cube
            res_nx = mv_in;
            mv_nx  = '0;
         end else if (mv_in_res) begin
            mv_nx  = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || wipe) begin
         mv_q  <= '0;
         res_q <= '0;
      end else if (step) begin
         mv_q  <= mv_nx;
         res_q <= res_nx;
      end
   end

endmodule

// File: rtl/cab_ctrl.sv
// Sequencing: collect a sum, drain the moving row, hand off the result.
module cab_ctrl #(
   parameter int DEPTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_last,
   input  logic emit_busy,
   output logic in_ready,
   output logic step,
   output logic feed_zero,
   output logic xfer
);
   import cab_pkg::*;

   localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CW-1:0] CNT_END = CW'(DEPTH - 1);

   cab_state_e    state_q;
   logic [CW-1:0] cnt_q;

   assign in_ready  = (state_q == CAB_COLLECT);
   assign feed_zero = (state_q == CAB_DRAIN);
   assign step      = (in_ready && in_valid) || feed_zero;
   assign xfer      = (state_q == CAB_XFER) && !emit_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CAB_COLLECT;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            CAB_COLLECT: begin
               if (in_valid && in_last) begin
                  state_q <= CAB_DRAIN;
                  cnt_q   <= '0;
               end
            end
            CAB_DRAIN: begin
               if (cnt_q == CNT_END) begin
                  state_q <= CAB_XFER;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            CAB_XFER: begin
               if (!emit_busy) begin
                  state_q <= CAB_COLLECT;
               end
            end
            default: state_q <= CAB_COLLECT;
         endcase
      end
   end

endmodule

// File: rtl/cab_emit.sv
// Output buffer: takes the resident row in one cycle, then streams the
// non-empty entries in ascending index order.
module cab_emit #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DEPTH*W-1:0] load_bus,
   output logic             out_valid,
   output logic [W-1:0]     out_cube,
   output logic             out_last
);

   localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]     slot_in [DEPTH];
   logic [W-1:0]     buf_q   [DEPTH];
   logic [DEPTH-1:0] live_in;
   logic [DEPTH-1:0] pend_q;
   logic [DEPTH-1:0] rest;
   logic             none_q;
   logic [SW-1:0]    sel;
   logic             found;

   for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
      assign slot_in[g] = load_bus[g*W +: W];
      assign live_in[g] = |slot_in[g];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            buf_q[g] <= '0;
         end else if (load) begin
            buf_q[g] <= slot_in[g];
         end
      end
   end

   always_comb begin
      sel   = '0;
      found = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (pend_q[i] && !found) begin
            sel   = SW'(i);
            found = 1'b1;
         end
      end
      rest      = pend_q;
      rest[sel] = 1'b0;
   end

   assign out_valid = found || none_q;
   assign out_cube  = none_q ? '0 : buf_q[sel];
   assign out_last  = none_q || (found && (rest == '0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         none_q <= 1'b0;
      end else if (load) begin
         pend_q <= live_in;
         none_q <= (live_in == '0);
      end else if (none_q) begin
         none_q <= 1'b0;
      end else if (found) begin
         pend_q <= rest;
      end
   end

endmodule

// File: rtl/cube_absorb_array.sv
module cube_absorb_array #(
   parameter int NVARS = 8,
   parameter int DEPTH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [2*NVARS-1:0] in_cube,
   input  logic               in_last,
   output logic               in_ready,
   output logic               out_valid,
   output logic [2*NVARS-1:0] out_cube,
   output logic               out_last
);

   localparam int W = 2 * NVARS;

   if (NVARS < 1) begin : g_chk_nvars
      $error("cube_absorb_array: NVARS must be at least 1");
   end
   if (DEPTH < 2) begin : g_chk_depth
      $error("cube_absorb_array: DEPTH must be at least 2");
   end

   logic             step;
   logic             feed_zero;
   logic             xfer;
   logic [NVARS-1:0] fld_void;
   logic [W-1:0]     entry;
   logic [W-1:0]     mv  [DEPTH];
   logic [W-1:0]     res [DEPTH];
   logic [DEPTH*W-1:0] res_bus;

   // contradiction filter at the entry
   for (genvar v = 0; v < NVARS; v++) begin : g_field
      assign fld_void[v] = ~|in_cube[2*v +: 2];
   end
   assign entry = (feed_zero || (|fld_void)) ? '0 : in_cube;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [W-1:0] feed;
      if (g == 0) begin : g_head
         assign feed = entry;
      end else begin : g_body
         assign feed = mv[g-1];
      end

      cab_cell #(.W(W)) cell_i (
         .clk   (clk),
         .rst_n (rst_n),
         .step  (step),
         .wipe  (xfer),
         .mv_in (feed),
         .mv_q  (mv[g]),
         .res_q (res[g])
      );

      assign res_bus[g*W +: W] = res[g];
   end

   cab_ctrl #(.DEPTH(DEPTH)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .emit_busy (out_valid),
      .in_ready  (in_ready),
      .step      (step),
      .feed_zero (feed_zero),
      .xfer      (xfer)
   );

   cab_emit #(.W(W), .DEPTH(DEPTH)) emit_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (xfer),
      .load_bus  (res_bus),
      .out_valid (out_valid),
      .out_cube  (out_cube),
      .out_last  (out_last)
   );

endmodule

// File: rtl/cab_checker.sv
module cab_checker #(
   parameter int NVARS = 8,
   parameter int DEPTH = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_last,
   input logic               in_ready,
   input logic               out_valid,
   input logic [2*NVARS-1:0] out_cube,
   input logic               out_last
);

   localparam int W = 2 * NVARS;

   function automatic logic has_void(input logic [W-1:0] c);
      for (int i = 0; i < NVARS; i++) begin
         if (c[2*i +: 2] == 2'b00) return 1'b1;
      end
      return 1'b0;
   endfunction

   logic [15:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || in_ready) begin
         low_cnt <= '0;
      end else if (low_cnt != 16'hFFFF) begin
         low_cnt <= low_cnt + 16'd1;
      end
   end

   a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> !in_ready);

   a_r8_drain_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> (low_cnt >= 16'(DEPTH + 1)));

   a_r9_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   a_r9_stream_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);

   a_r1_no_void_out: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_cube != '0)) |-> !has_void(out_cube));

   a_r10_zero_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_cube == '0)) |-> out_last);

   a_r11_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |=> !out_valid);

endmodule

bind cube_absorb_array cab_checker #(.NVARS(NVARS), .DEPTH(DEPTH)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_last   (in_last),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_cube  (out_cube),
   .out_last  (out_last)
);

// File: tb/cube_absorb_array_tb_top.sv
`timescale 1ns/1ps
module cube_absorb_array_tb_top;

   localparam int NV = 3;
   localparam int DP = 4;
   localparam int TW = 2 * NV;
   localparam int GMAX = 8192;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [TW-1:0] in_cube = '0;
   logic          in_last = 1'b0;
   logic          in_ready;
   logic          out_valid;
   logic [TW-1:0] out_cube;
   logic          out_last;

   always #5 clk = ~clk;

   cube_absorb_array #(.NVARS(NV), .DEPTH(DP)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_cube   (in_cube),
      .in_last   (in_last),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_cube  (out_cube),
      .out_last  (out_last)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // output capture
   logic [TW-1:0] got_cube [GMAX];
   logic          got_last [GMAX];
   int            gw = 0;
   int            rp = 0;

   always @(negedge clk) begin
      if (rst_n && out_valid && gw < GMAX) begin
         got_cube[gw] = out_cube;
         got_last[gw] = out_last;
         gw = gw + 1;
      end
   end

   // stimulus and model storage
   logic [TW-1:0] stim [16];
   logic [TW-1:0] exp_c [DP];
   int            exp_n;
   logic [TW-1:0] sav_c [DP];
   int            sav_n;
   logic [15:0]   lfsr = 16'hACE1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [TW-1:0] enc(input int n);
      logic [TW-1:0] c;
      int            r;
      r = n;
      for (int v = 0; v < NV; v++) begin
         case (r % 3)
            0: c[2*v +: 2] = 2'b10;
            1: c[2*v +: 2] = 2'b01;
            default: c[2*v +: 2] = 2'b11;
         endcase
         r = r / 3;
      end
      return c;
   endfunction

   function automatic bit is_void(input logic [TW-1:0] c);
      for (int v = 0; v < NV; v++) begin
         if (c[2*v +: 2] == 2'b00) return 1'b1;
      end
      return 1'b0;
   endfunction

   // sequential model of the slot rules
   task automatic run_model(input int len);
      logic [TW-1:0] slot [DP];
      logic [TW-1:0] m;
      for (int k = 0; k < DP; k++) slot[k] = '0;
      for (int i = 0; i < len; i++) begin
         m = is_void(stim[i]) ? '0 : stim[i];
         for (int k = 0; k < DP; k++) begin
            if (m != '0) begin
               if (slot[k] == '0 || (slot[k] & ~m) == '0) begin
                  slot[k] = m;
                  m = '0;
               end else if ((m & ~slot[k]) == '0) begin
                  m = '0;
               end
            end
         end
      end
      exp_n = 0;
      for (int k = 0; k < DP; k++) begin
         if (slot[k] != '0) begin
            exp_c[exp_n] = slot[k];
            exp_n++;
         end
      end
      if (exp_n == 0) begin
         exp_c[0] = '0;
         exp_n = 1;
      end
   endtask

   task automatic send_sum(input int len);
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b0;
         while (!in_ready) @(negedge clk);
         in_valid = 1'b1;
         in_cube  = stim[i];
         in_last  = (i == len - 1);
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   function automatic int find_last(input int from);
      for (int j = from; j < gw; j++) begin
         if (got_last[j]) return j;
      end
      return -1;
   endfunction

   task automatic check_stream(input string tag);
      int li;
      li = find_last(rp);
      while (li < 0) begin
         @(posedge clk);
         li = find_last(rp);
      end
      check((li - rp + 1) == exp_n, "R9 beat count", li - rp + 1, exp_n);
      for (int j = 0; j < exp_n && (rp + j) <= li; j++) begin
         check(got_cube[rp + j] == exp_c[j], tag, int'(got_cube[rp + j]), int'(exp_c[j]));
      end
      rp = li + 1;
   endtask

   task automatic lfsr_step();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [TW-1:0] ca;
      logic [TW-1:0] cb;
      int            len;

      // R2: reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R2 out_valid in reset", out_valid, 0);
      check(in_ready == 1'b1, "R2 in_ready in reset", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R2 out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R2 in_ready after reset", in_ready, 1);

      // R4/R8/R9: single cube, exact window, ignored input during drain
      ca = 6'b11_11_10;
      in_valid = 1'b1; in_cube = ca; in_last = 1'b1;
      @(negedge clk);
      in_cube = 6'b11_10_11;   // held during drain, must be ignored
      for (int k = 1; k <= DP + 1; k++) begin
         check(in_ready == 1'b0, "R8 in_ready low in drain", in_ready, 0);
         check(out_valid == 1'b0, "R9 no beat before window", out_valid, 0);
         @(negedge clk);
      end
      check(in_ready == 1'b1, "R8 in_ready back", in_ready, 1);
      check(out_valid == 1'b1, "R9 first beat timing", out_valid, 1);
      check(out_cube == ca, "R4 cube placed in empty slot", out_cube, ca);
      check(out_last == 1'b1, "R9 single beat is last", out_last, 1);
      in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R11 idle after last", out_valid, 0);
      rp = gw;
      stim[0] = 6'b01_11_11;
      run_model(1);
      send_sum(1);
      check_stream("R8 ignored drain input absent");

      // exhaustive ordered pairs
      for (int a = 0; a < 27; a++) begin
         for (int b = 0; b < 27; b++) begin
            ca = enc(a);
            cb = enc(b);
            stim[0] = ca;
            stim[1] = cb;
            run_model(2);
            send_sum(2);
            if ((ca & ~cb) == '0)
               check_stream("R5 resident replaced");
            else if ((cb & ~ca) == '0)
               check_stream("R6 moving erased");
            else
               check_stream("R7 incomparable kept");
         end
      end

      // R1/R10: contradictory inputs only
      stim[0] = 6'b00_11_11;
      stim[1] = 6'b11_00_10;
      stim[2] = 6'b00_00_00;
      run_model(3);
      send_sum(3);
      check_stream("R10 empty result marker");
      check(exp_c[0] == '0 && exp_n == 1, "R10 model marker", exp_n, 1);

      // R1: contradictory input mixed with valid ones
      stim[0] = 6'b10_00_11;
      stim[1] = 6'b10_11_11;
      stim[2] = 6'b10_01_11;
      run_model(3);
      send_sum(3);
      check_stream("R1 void dropped");

      // R7: overflow, five pairwise incomparable minterms
      for (int i = 0; i < 5; i++) begin
         stim[i] = {(i[2] ? 2'b01 : 2'b10), (i[1] ? 2'b01 : 2'b10), (i[0] ? 2'b01 : 2'b10)};
      end
      run_model(5);
      send_sum(5);
      check_stream("R7 overflow keeps first DEPTH");
      check(exp_n == DP, "R7 model keeps DEPTH", exp_n, DP);

      // R11: back-to-back sums, second accepted while first streams
      for (int i = 0; i < 4; i++) begin
         stim[i] = {2'b11, (i[1] ? 2'b01 : 2'b10), (i[0] ? 2'b01 : 2'b10)};
      end
      run_model(4);
      sav_n = exp_n;
      for (int k = 0; k < DP; k++) sav_c[k] = exp_c[k];
      send_sum(4);
      while (!in_ready) @(negedge clk);
      check(out_valid == 1'b1, "R11 accept during stream", out_valid, 1);
      stim[0] = 6'b11_11_01;
      stim[1] = 6'b10_11_01;
      send_sum(2);
      exp_n = sav_n;
      for (int k = 0; k < DP; k++) exp_c[k] = sav_c[k];
      check_stream("R11 first sum");
      run_model(2);
      check_stream("R11 second sum");

      // R3/R12: pseudo-random sums, digit 3 of a field makes a contradiction
      for (int s = 0; s < 250; s++) begin
         lfsr_step();
         len = 1 + (lfsr % 6);
         for (int i = 0; i < len; i++) begin
            for (int v = 0; v < NV; v++) begin
               lfsr_step();
               case (lfsr[1:0])
                  2'd0: stim[i][2*v +: 2] = 2'b10;
                  2'd1: stim[i][2*v +: 2] = 2'b01;
                  2'd2: stim[i][2*v +: 2] = 2'b11;
                  default: stim[i][2*v +: 2] = (lfsr[7:4] == 4'd0) ? 2'b00 : 2'b11;
               endcase
            end
         end
         run_model(len);
         send_sum(len);
         check_stream("R3 R12 random sum");
      end

      repeat (4) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule